// File: doc/BRIEF.md
# External Interrupt Sense Controller

This block turns external interrupt pins into per-source interrupt requests for a small microcontroller core. It has a configurable number of clock-sampled pins (two by default). Each one carries a two-bit sense code that picks one of four triggers: low level, any change, falling edge or rising edge. One further pin is edge-only. A single select bit picks its polarity, and its edges are caught by a flop clocked by the pin itself, so a pulse shorter than a system clock period is still recorded.

Software reaches three byte-wide registers through a simple write-strobe and combinational-read port: sense modes, per-source enables and pending flags. A pending flag is cleared by writing a one to it, or by a one-cycle acknowledge pulse from the core. A request is presented only when the core's global interrupt-enable input and the source's own enable are both set. Vector fetch and arbitration between sources belong to the core.

Top module: `extirq_sense_ctrl`

## Requirements
- R1: While reset is asserted and afterwards until software writes, every register reads zero and every request output is low.
- R2: A clock-sampled pin is passed through two synchronizing flops and compared with the previous sample. Sense code 01 sets its flag on any change, 10 on a falling edge and 11 on a rising edge. The flag is readable three clock edges after the pin changes. Any pulse lasting longer than one clock period is caught.
- R3: `irq_req[j]` is high only when `global_ie` is high and the enable bit of source j is set. Given both, it follows that source's pending condition.
- R4: Register map (address: contents). Address 0 is sense modes: bits [1:0] for source 0, [3:2] for source 1, bit 4 selecting the edge-only pin's polarity. Address 1 holds the enables and address 2 the flags: bit 6 is source 0, bit 7 is source 1 and bit 5 is the edge-only source. Unused bits read zero. Request and acknowledge index 0 and 1 are the clock-sampled sources and index 2 is the edge-only source.
- R5: With sense code 00 the request follows the synchronized pin low level. It appears two clock edges after the pin falls and drops once the pin returns high, so it is never latched. The flag is not set in this mode.
- R6: The edge-only pin sets its flag on a falling edge when the select bit is 0 and on a rising edge when it is 1. This holds even for pulses much shorter than a clock period. The flag is readable three clock edges after the edge.
- R7: Writing a one to a flag bit clears that flag. Writing a zero leaves it unchanged.
- R8: A one-cycle pulse on `irq_ack[j]` clears the flag of source j.
- R9: If a new trigger arrives on the same clock edge that a clear is applied, the flag stays set.
- R10: Changing the edge-only polarity select can itself set the flag. Going from 0 to 1 while the pin is high sets it. Going from 1 to 0 while the pin is high does not.
- R11: The sample history resets to the idle-high pin level, so pins held high through reset raise no flag in any sense mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| global_ie | input | 1 | Core global interrupt enable |
| sync_pin | input | NUM_SYNC | Clock-sampled interrupt pins |
| async_pin | input | 1 | Edge-only interrupt pin, captured without the clock |
| reg_addr | input | ADDR_W | Register address |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for `reg_addr` (combinational) |
| irq_ack | input | NUM_SYNC+1 | Per-source acknowledge pulse |
| irq_req | output | NUM_SYNC+1 | Per-source interrupt request |

## Verification
The hardest case to reach from the ports is a fresh trigger on exactly the clock edge that a write-one-to-clear takes effect. The bench first pends the flag. It then drives a new falling edge on a negative clock edge and waits two clock edges. Finally it issues the clearing write across the third edge, where the synchronized edge lands, and reads the flag back. The spurious flag from a polarity change is reached by writing the select while the edge-only pin sits high. A sub-clock pulse of 7 ns then shows that capture works without the system clock.

// File: rtl/extirq_pkg.sv
`timescale 1ns/1ps
package extirq_pkg;
   typedef enum logic [1:0] {
      SENSE_LOW  = 2'b00,
      SENSE_ANY  = 2'b01,
      SENSE_FALL = 2'b10,
      SENSE_RISE = 2'b11
   } sense_e;

   localparam int ADDR_MODE = 0;
   localparam int ADDR_EN   = 1;
   localparam int ADDR_FLAG = 2;
endpackage

// File: rtl/extirq_sync_src.sv
`timescale 1ns/1ps
module extirq_sync_src
   import extirq_pkg::*;
#(
   parameter bit PIN_IDLE = 1'b1
) (
   input  logic   clk,
   input  logic   rst_n,
   input  logic   pin,
   input  sense_e mode,
   input  logic   clr,
   output logic   flag,
   output logic   req_raw
);
   logic smp_a, smp_b, smp_prev;
   logic hit;

   // two-flop synchronizer plus previous sample, all reset to the idle level
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         smp_a    <= PIN_IDLE;
         smp_b    <= PIN_IDLE;
         smp_prev <= PIN_IDLE;
      end else begin
         smp_a    <= pin;
         smp_b    <= smp_a;
         smp_prev <= smp_b;
      end
   end

   always_comb begin
      unique case (mode)
         SENSE_LOW:  hit = 1'b0;
         SENSE_ANY:  hit = smp_b ^ smp_prev;
         SENSE_FALL: hit = smp_prev & ~smp_b;
         SENSE_RISE: hit = ~smp_prev & smp_b;
         default:    hit = 1'b0;
      endcase
   end

   // a new trigger wins over a clear in the same cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   flag <= 1'b0;
      else if (hit) flag <= 1'b1;
      else if (clr) flag <= 1'b0;
   end

   assign req_raw = (mode == SENSE_LOW) ? ~smp_b : flag;
endmodule

// File: rtl/extirq_async_src.sv
`timescale 1ns/1ps
module extirq_async_src (
   input  logic clk,
   input  logic rst_n,
   input  logic pin,
   input  logic rising,
   input  logic clr,
   output logic flag
);
   logic cap_clk;
   logic edge_tog;
   logic sy_a, sy_b, sy_prev;
   logic hit;

   assign cap_clk = rising ? pin : ~pin;

   // edge capture clocked by the pin itself
   always_ff @(posedge cap_clk or negedge rst_n) begin
      if (!rst_n) edge_tog <= 1'b0;
      else        edge_tog <= ~edge_tog;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sy_a    <= 1'b0;
         sy_b    <= 1'b0;
         sy_prev <= 1'b0;
      end else begin
         sy_a    <= edge_tog;
         sy_b    <= sy_a;
         sy_prev <= sy_b;
      end
   end

   assign hit = sy_b ^ sy_prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   flag <= 1'b0;
      else if (hit) flag <= 1'b1;
      else if (clr) flag <= 1'b0;
   end
endmodule

// File: rtl/extirq_sense_ctrl.sv
`timescale 1ns/1ps
module extirq_sense_ctrl
   import extirq_pkg::*;
#(
   parameter int NUM_SYNC = 2,
   parameter int DATA_W   = 8,
   parameter int ADDR_W   = 2,
   parameter bit PIN_IDLE = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                global_ie,
   input  logic [NUM_SYNC-1:0] sync_pin,
   input  logic                async_pin,
   input  logic [ADDR_W-1:0]   reg_addr,
   input  logic                reg_wr,
   input  logic [DATA_W-1:0]   reg_wdata,
   output logic [DATA_W-1:0]   reg_rdata,
   input  logic [NUM_SYNC:0]   irq_ack,
   output logic [NUM_SYNC:0]   irq_req
);
   localparam int NUM_SRC  = NUM_SYNC + 1;
   localparam int ASYNC_IX = NUM_SYNC;
   localparam int SRC_LSB  = DATA_W - NUM_SRC;
   localparam int ASEL_BIT = 2 * NUM_SYNC;

   if (NUM_SYNC < 1) begin : g_chk_nsync
      $error("NUM_SYNC must be at least 1");
   end
   if (ASEL_BIT + 1 > DATA_W) begin : g_chk_mode_w
      $error("DATA_W too narrow for the sense-mode register");
   end
   if (ADDR_W < 2) begin : g_chk_addr_w
      $error("ADDR_W must be at least 2");
   end

   function automatic int src_bit(input int j);
      return (j == ASYNC_IX) ? SRC_LSB : SRC_LSB + 1 + j;
   endfunction

   logic [NUM_SYNC-1:0][1:0] sense_q;
   logic                     asel_q;
   logic [NUM_SRC-1:0]       en_q;
   logic [NUM_SRC-1:0]       flags;
   logic [NUM_SRC-1:0]       flag_clr;
   logic [NUM_SRC-1:0]       raw_req;
   logic [2*NUM_SYNC-1:0]    sense_flat;
   logic                     sel_mode, sel_en, sel_flag;

   assign sel_mode = reg_wr && (reg_addr == ADDR_W'(ADDR_MODE));
   assign sel_en   = reg_wr && (reg_addr == ADDR_W'(ADDR_EN));
   assign sel_flag = reg_wr && (reg_addr == ADDR_W'(ADDR_FLAG));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sense_q <= '0;
         asel_q  <= 1'b0;
         en_q    <= '0;
      end else begin
         if (sel_mode) begin
            for (int i = 0; i < NUM_SYNC; i++) sense_q[i] <= reg_wdata[2*i +: 2];
            asel_q <= reg_wdata[ASEL_BIT];
         end
         if (sel_en) begin
            for (int j = 0; j < NUM_SRC; j++) en_q[j] <= reg_wdata[src_bit(j)];
         end
      end
   end

   always_comb begin
      for (int j = 0; j < NUM_SRC; j++)
         flag_clr[j] = (sel_flag && reg_wdata[src_bit(j)]) || irq_ack[j];
   end

   for (genvar g = 0; g < NUM_SYNC; g++) begin : g_sync
      extirq_sync_src #(.PIN_IDLE(PIN_IDLE)) u_src (
         .clk     (clk),
         .rst_n   (rst_n),
         .pin     (sync_pin[g]),
         .mode    (sense_e'(sense_q[g])),
         .clr     (flag_clr[g]),
         .flag    (flags[g]),
         .req_raw (raw_req[g])
      );
      assign sense_flat[2*g +: 2] = sense_q[g];
   end

   extirq_async_src u_async (
      .clk    (clk),
      .rst_n  (rst_n),
      .pin    (async_pin),
      .rising (asel_q),
      .clr    (flag_clr[ASYNC_IX]),
      .flag   (flags[ASYNC_IX])
   );
   assign raw_req[ASYNC_IX] = flags[ASYNC_IX];

   always_comb begin
      reg_rdata = '0;
      if (reg_addr == ADDR_W'(ADDR_MODE)) begin
         for (int i = 0; i < NUM_SYNC; i++) reg_rdata[2*i +: 2] = sense_q[i];
         reg_rdata[ASEL_BIT] = asel_q;
      end else if (reg_addr == ADDR_W'(ADDR_EN)) begin
         for (int j = 0; j < NUM_SRC; j++) reg_rdata[src_bit(j)] = en_q[j];
      end else if (reg_addr == ADDR_W'(ADDR_FLAG)) begin
         for (int j = 0; j < NUM_SRC; j++) reg_rdata[src_bit(j)] = flags[j];
      end
   end

   assign irq_req = raw_req & en_q & {NUM_SRC{global_ie}};
endmodule

// File: rtl/extirq_sense_chk.sv
`timescale 1ns/1ps
module extirq_sense_chk #(
   parameter int NUM_SYNC = 2
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  global_ie,
   input logic [NUM_SYNC-1:0]   sync_pin,
   input logic [NUM_SYNC:0]     irq_req,
   input logic [NUM_SYNC:0]     en_q,
   input logic [NUM_SYNC:0]     flags,
   input logic [NUM_SYNC:0]     flag_clr,
   input logic [2*NUM_SYNC-1:0] sense_flat
);
   logic [2:0] since_rst;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 since_rst <= '0;
      else if (since_rst != 3'd7) since_rst <= since_rst + 3'd1;
   end

   // R3: a request needs the global enable and the source enable
   p_req_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (|irq_req) |-> (global_ie && ((irq_req & ~en_q) == '0)));

   for (genvar j = 0; j <= NUM_SYNC; j++) begin : g_all
      // R7: a flag only falls after a clear request
      p_flag_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
         $fell(flags[j]) |-> $past(flag_clr[j]));
   end

   for (genvar i = 0; i < NUM_SYNC; i++) begin : g_syn
      // R5: level mode request tracks the pin two edges back
      p_level_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
         (since_rst >= 3'd3 && sense_flat[2*i +: 2] == 2'b00 && en_q[i] && global_ie)
         |-> (irq_req[i] == !$past(sync_pin[i], 2)));
      // R5: level mode never sets the flag
      p_level_noflag_r5: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(flags[i]) |-> ($past(sense_flat[2*i +: 2]) != 2'b00));
      // R2: rising edge sets the flag
      p_rise_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
         (since_rst >= 3'd5 && $past(sense_flat[2*i +: 2]) == 2'b11 &&
          $past(sync_pin[i], 3) && !$past(sync_pin[i], 4)) |-> flags[i]);
      // R2: falling edge sets the flag
      p_fall_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
         (since_rst >= 3'd5 && $past(sense_flat[2*i +: 2]) == 2'b10 &&
          !$past(sync_pin[i], 3) && $past(sync_pin[i], 4)) |-> flags[i]);
   end
endmodule

bind extirq_sense_ctrl extirq_sense_chk #(.NUM_SYNC(NUM_SYNC)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .global_ie  (global_ie),
   .sync_pin   (sync_pin),
   .irq_req    (irq_req),
   .en_q       (en_q),
   .flags      (flags),
   .flag_clr   (flag_clr),
   .sense_flat (sense_flat)
);

// File: tb/extirq_sense_ctrl_bench.sv
`timescale 1ns/1ps
module extirq_sense_ctrl_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       global_ie = 1'b0;
   logic [1:0] sync_pin = 2'b11;
   logic       async_pin = 1'b1;
   logic [1:0] reg_addr = '0;
   logic       reg_wr = 1'b0;
   logic [7:0] reg_wdata = '0;
   logic [7:0] reg_rdata;
   logic [2:0] irq_ack = '0;
   logic [2:0] irq_req;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   extirq_sense_ctrl u_extirq_sense_ctrl (
      .clk(clk), .rst_n(rst_n), .global_ie(global_ie),
      .sync_pin(sync_pin), .async_pin(async_pin),
      .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .irq_ack(irq_ack), .irq_req(irq_req)
   );

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      cyc(1);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [7:0] d);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   function automatic logic [7:0] fpos(input int src);
      return (src == 2) ? 8'h20 : (src == 0 ? 8'h40 : 8'h80);
   endfunction

   initial begin
      logic [7:0] v;
      // R1: reset state
      cyc(2);
      for (int a = 0; a < 3; a++) begin
         rd(2'(a), v);
         chk($sformatf("R1 reg %0d in reset", a), v, 8'h00);
      end
      chk("R1 req in reset", irq_req, 3'b000);
      rst_n = 1'b1;
      // R11: any-change on both, pins idle high -> no flag
      wr(0, 8'h05);
      cyc(5);
      rd(2, v); chk("R11 no startup flag", v, 8'h00);
      chk("R1 req after reset", irq_req, 3'b000);

      // R4: register map readback
      wr(0, 8'hEE); rd(0, v); chk("R4 mode readback", v, 8'h0E);
      wr(1, 8'hFF); rd(1, v); chk("R4 enable readback", v, 8'hE0);
      global_ie = 1'b1;

      // R2/R5: sweep every sense code on each clock-sampled source
      for (int s = 0; s < 2; s++) begin
         for (int m = 0; m < 4; m++) begin
            logic ef, er;
            wr(0, 8'(m << (2 * s)));
            wr(2, 8'hFF);
            cyc(1);
            sync_pin[s] = 1'b0;
            cyc(3);
            ef = (m == 1) || (m == 2);
            er = (m == 0) ? 1'b1 : ef;
            rd(2, v);
            chk($sformatf("R2 src%0d mode%0d fall flag", s, m), v, ef ? fpos(s) : 8'h00);
            chk($sformatf("R5 src%0d mode%0d fall req", s, m), irq_req[s], er);
            wr(2, 8'hFF);
            rd(2, v);
            chk($sformatf("R7 src%0d mode%0d cleared", s, m), v, 8'h00);
            chk($sformatf("R5 src%0d mode%0d held low req", s, m), irq_req[s], m == 0);
            sync_pin[s] = 1'b1;
            cyc(3);
            ef = (m == 1) || (m == 3);
            er = (m == 0) ? 1'b0 : ef;
            rd(2, v);
            chk($sformatf("R2 src%0d mode%0d rise flag", s, m), v, ef ? fpos(s) : 8'h00);
            chk($sformatf("R5 src%0d mode%0d rise req", s, m), irq_req[s], er);
         end
      end

      // R2: pulse slightly over one clock period: src0 rising, src1 falling
      wr(0, 8'h0B);
      wr(2, 8'hFF);
      sync_pin = 2'b00;
      #25 sync_pin = 2'b11;
      cyc(4);
      rd(2, v); chk("R2 short pulse both edges", v, 8'hC0);

      // R6: falling edge on edge-only pin with select 0
      async_pin = 1'b0; cyc(1); async_pin = 1'b1; cyc(3);
      rd(2, v); chk("R6 async falling", v, 8'hE0);

      // R3: gating sweep over global enable and all source enables
      for (int g = 0; g < 2; g++) begin
         for (int e = 0; e < 8; e++) begin
            global_ie = g[0];
            wr(1, {e[1], e[0], e[2], 5'b0});
            chk($sformatf("R3 gie%0d en%0d", g, e), irq_req, g ? 3'(e) : 3'b000);
         end
      end

      // R7: zero write no effect, one clears only its bit
      wr(2, 8'h00); rd(2, v); chk("R7 zero write keeps", v, 8'hE0);
      wr(2, 8'h40); rd(2, v); chk("R7 one write clears src0", v, 8'hA0);
      // R8: acknowledge clears
      irq_ack = 3'b010; cyc(1); irq_ack = 3'b000;
      rd(2, v); chk("R8 ack src1", v, 8'h20);
      irq_ack = 3'b100; cyc(1); irq_ack = 3'b000;
      rd(2, v); chk("R8 ack async", v, 8'h00);

      // R10: select 0->1 while pin high raises a flag
      wr(0, 8'h10); cyc(3);
      rd(2, v); chk("R10 select change sets flag", v, 8'h20);
      wr(2, 8'hFF);
      // R6: rising select ignores falling, catches rising
      async_pin = 1'b0; cyc(3);
      rd(2, v); chk("R6 rising sel ignores fall", v, 8'h00);
      async_pin = 1'b1; cyc(3);
      rd(2, v); chk("R6 rising sel catches rise", v, 8'h20);
      wr(2, 8'hFF);
      // R10: select 1->0 with pin high raises nothing
      wr(0, 8'h00); cyc(3);
      rd(2, v); chk("R10 select back no flag", v, 8'h00);
      // R6: pulse far shorter than a clock period
      async_pin = 1'b0; #7 async_pin = 1'b1;
      cyc(4);
      rd(2, v); chk("R6 sub-clock pulse", v, 8'h20);
      wr(2, 8'hFF);

      // R9: new trigger on the clearing edge keeps the flag
      wr(0, 8'h02);
      sync_pin[0] = 1'b0; cyc(3);
      sync_pin[0] = 1'b1; cyc(3);
      rd(2, v); chk("R9 flag pending before", v, 8'h40);
      sync_pin[0] = 1'b0; cyc(2);
      wr(2, 8'h40);
      rd(2, v); chk("R9 set wins over clear", v, 8'h40);
      wr(2, 8'h40);
      rd(2, v); chk("R7 later clear", v, 8'h00);
      sync_pin[0] = 1'b1;
      cyc(3);

      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      #2000000;
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog all requirements actual=hung expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   end
endmodule